// File: doc/BRIEF.md
# Hardware Debug Breakpoint Unit

This block sits beside a 32-bit processor core as a coprocessor-style debug unit. It provides one breakpoint on the instruction fetch address and one on the load/store address. Each breakpoint has an address register and a mask register. A control word arms the unit and selects which privilege modes and which access kinds may trigger. Its low bits are sticky flags that record why the last trap happened. Software reaches the five registers through a plain register port: an index, a write strobe, write data and combinational read data.

Each cycle the unit compares the presented fetch PC and data address against the breakpoint registers. Only the bit positions selected by the mask take part in a compare. A match that passes every enable produces a one-cycle debug request in the same cycle as the access. The flags that describe it are latched at the next clock edge. To express an address range, keep the high-order bits that both ends of the range share, and clear the mask below them. A single-step trace mode raises a request on every enabled fetch.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset the control word (index 0) reads 0, both address registers (index 1 = PC address, index 3 = data address) read 0, both mask registers (index 2 = PC mask, index 4 = data mask) read all ones, and no request is raised.
- R2: Control bit positions are: 31 trap enable, 30 user enable, 29 kernel enable, 28 trace enable, 27 data-write enable, 26 data-read enable, 25 data-address enable, 24 PC enable, 23 master enable. Status bit positions are: 5 trace hit, 4 write hit, 3 read hit, 2 data-address hit, 1 PC hit, 0 debug-taken. Bits 22:6 read as zero, and writes to them are ignored.
- R3: A fetch triggers the PC breakpoint when ((pc XOR addr) AND mask) is zero. Only mask bits set to 1 are compared, so an all-ones mask requires an exact 32-bit match.
- R4: A PC breakpoint needs PC enable, master enable, trap enable and the enable for the current mode.
- R5: With user_mode high, a match is ignored unless user enable is set. With user_mode low, a match is ignored unless kernel enable is set.
- R6: A data breakpoint needs data-address enable. It fires on a read (mem_write=0) only when data-read enable is set, and on a write only when data-write enable is set.
- R7: dbg_req is high in the same cycle as the matching fetch or access, and only in that cycle.
- R8: On a trigger, the flags of every condition that hit, together with debug-taken, are set at the next clock edge. They stay set until software writes the control word. A control write in the same cycle as a hit takes precedence.
- R9: If the PC and data breakpoints match in the same cycle, both sets of flags are recorded and a single request is raised.
- R10: Writing zero to the control word disarms every breakpoint.
- R11: With trace enable set (plus master, trap and mode enables), every valid fetch raises a request and sets the trace-hit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 3 | Register index for the software port |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| user_mode | input | 1 | High when the core runs in user mode, low in kernel mode |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | 32 | Fetch address |
| mem_valid | input | 1 | A load or store is presented this cycle |
| mem_write | input | 1 | 1 = store, 0 = load |
| mem_addr | input | 32 | Load/store address |
| dbg_req | output | 1 | Debug exception request pulse |

## Verification
The PC compare is exercised with a table of masks: exact, a cleared top bit, a cleared low byte, and an all-zero mask. Addresses are chosen one past the masked field and differing only in a masked-off bit, so a comparator that ignores the mask, or that inverts it, is caught. Data accesses are driven as reads and writes under read-only and write-only arming, to show that the direction gates work separately. Mode gating is checked with the user enable clear in both modes. A simultaneous fetch and load confirms that both flag groups combine into one request. The flag word is read back after non-matching accesses, to tell sticky flags apart from flags that merely follow the current access.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
    localparam int CW    = 32;
    localparam int IDX_W = 3;

    localparam int B_TRAP = 31;
    localparam int B_USER = 30;
    localparam int B_KERN = 29;
    localparam int B_TRCE = 28;
    localparam int B_DWR  = 27;
    localparam int B_DRD  = 26;
    localparam int B_DADR = 25;
    localparam int B_PCEN = 24;
    localparam int B_MSTR = 23;

    localparam int S_TRCE = 5;
    localparam int S_WR   = 4;
    localparam int S_RD   = 3;
    localparam int S_DA   = 2;
    localparam int S_PC   = 1;
    localparam int S_TKN  = 0;

    localparam logic [CW-1:0] CTRL_WMASK = 32'hFF80_003F;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL    = 3'd0,
        IDX_PC_ADDR = 3'd1,
        IDX_PC_MASK = 3'd2,
        IDX_DA_ADDR = 3'd3,
        IDX_DA_MASK = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic trap;
        logic user;
        logic kern;
        logic trace;
        logic dwr;
        logic drd;
        logic daddr;
        logic pcen;
        logic master;
    } arm_t;

    typedef struct packed {
        logic trace;
        logic pc;
        logic da;
        logic rd;
        logic wr;
    } hit_t;

    function automatic arm_t decode_arm(input logic [CW-1:0] c);
        arm_t a;
        a.trap   = c[B_TRAP];
        a.user   = c[B_USER];
        a.kern   = c[B_KERN];
        a.trace  = c[B_TRCE];
        a.dwr    = c[B_DWR];
        a.drd    = c[B_DRD];
        a.daddr  = c[B_DADR];
        a.pcen   = c[B_PCEN];
        a.master = c[B_MSTR];
        return a;
    endfunction

    function automatic logic [CW-1:0] flag_bits(input hit_t h);
        logic [CW-1:0] f;
        f = '0;
        f[S_TRCE] = h.trace;
        f[S_WR]   = h.wr;
        f[S_RD]   = h.rd;
        f[S_DA]   = h.da;
        f[S_PC]   = h.pc;
        f[S_TKN]  = h.trace | h.pc | h.da;
        return f;
    endfunction
endpackage

// File: rtl/dbg_addr_match.sv
module dbg_addr_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] bp_addr,
    input  logic [AW-1:0] bp_mask,
    output logic          match
);
    logic [AW-1:0] diff;
    always_comb begin
        diff  = (addr_in ^ bp_addr) & bp_mask;
        match = (diff == '0);
    end
endmodule

// File: rtl/dbg_trigger.sv
module dbg_trigger
    import dbg_bkpt_pkg::*;
(
    input  arm_t arm,
    input  logic user_mode,
    input  logic fetch_valid,
    input  logic pc_match,
    input  logic mem_valid,
    input  logic mem_write,
    input  logic da_match,
    output hit_t hit,
    output logic req
);
    logic mode_ok;
    logic common;
    logic dir_ok;

    always_comb begin
        mode_ok   = user_mode ? arm.user : arm.kern;
        common    = arm.master & arm.trap & mode_ok;
        dir_ok    = mem_write ? arm.dwr : arm.drd;
        hit.pc    = common & arm.pcen & fetch_valid & pc_match;
        hit.trace = common & arm.trace & fetch_valid;
        hit.da    = common & arm.daddr & mem_valid & da_match & dir_ok;
        hit.rd    = hit.da & ~mem_write;
        hit.wr    = hit.da & mem_write;
        req       = hit.pc | hit.trace | hit.da;
    end
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_bkpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             reg_we,
    input  logic [CW-1:0]    reg_wdata,
    output logic [CW-1:0]    reg_rdata,
    input  hit_t             hit,
    output logic [CW-1:0]    ctrl_q,
    output logic [AW-1:0]    pc_addr_q,
    output logic [AW-1:0]    pc_mask_q,
    output logic [AW-1:0]    da_addr_q,
    output logic [AW-1:0]    da_mask_q
);
    reg_idx_e idx;
    assign idx = reg_idx_e'(reg_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            pc_addr_q <= '0;
            pc_mask_q <= '1;
            da_addr_q <= '0;
            da_mask_q <= '1;
        end else begin
            if (reg_we && idx == IDX_CTRL)
                ctrl_q <= reg_wdata & CTRL_WMASK;
            else
                ctrl_q <= ctrl_q | flag_bits(hit);
            if (reg_we) begin
                case (idx)
                    IDX_PC_ADDR: pc_addr_q <= reg_wdata[AW-1:0];
                    IDX_PC_MASK: pc_mask_q <= reg_wdata[AW-1:0];
                    IDX_DA_ADDR: da_addr_q <= reg_wdata[AW-1:0];
                    IDX_DA_MASK: da_mask_q <= reg_wdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_CTRL:    reg_rdata = ctrl_q;
            IDX_PC_ADDR: reg_rdata[AW-1:0] = pc_addr_q;
            IDX_PC_MASK: reg_rdata[AW-1:0] = pc_mask_q;
            IDX_DA_ADDR: reg_rdata[AW-1:0] = da_addr_q;
            IDX_DA_MASK: reg_rdata[AW-1:0] = da_mask_q;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             reg_we,
    input  logic [CW-1:0]    reg_wdata,
    output logic [CW-1:0]    reg_rdata,
    input  logic             user_mode,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             mem_valid,
    input  logic             mem_write,
    input  logic [AW-1:0]    mem_addr,
    output logic             dbg_req
);
    logic [CW-1:0] ctrl_q;
    logic [AW-1:0] pc_addr_q, pc_mask_q, da_addr_q, da_mask_q;
    logic          pc_match, da_match;
    hit_t          hit;
    arm_t          arm;

    assign arm = decode_arm(ctrl_q);

    dbg_regfile #(.AW(AW)) i_regs (
        .clk(clk), .rst(rst),
        .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hit(hit), .ctrl_q(ctrl_q),
        .pc_addr_q(pc_addr_q), .pc_mask_q(pc_mask_q),
        .da_addr_q(da_addr_q), .da_mask_q(da_mask_q)
    );

    dbg_addr_match #(.AW(AW)) i_pc_cmp (
        .addr_in(fetch_pc), .bp_addr(pc_addr_q),
        .bp_mask(pc_mask_q), .match(pc_match)
    );

    dbg_addr_match #(.AW(AW)) i_da_cmp (
        .addr_in(mem_addr), .bp_addr(da_addr_q),
        .bp_mask(da_mask_q), .match(da_match)
    );

    dbg_trigger i_trig (
        .arm(arm), .user_mode(user_mode),
        .fetch_valid(fetch_valid), .pc_match(pc_match),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .da_match(da_match), .hit(hit), .req(dbg_req)
    );
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk
    import dbg_bkpt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] reg_idx,
    input logic             reg_we,
    input logic [CW-1:0]    reg_wdata,
    input logic             fetch_valid,
    input logic             mem_valid,
    input logic             mem_write,
    input logic             dbg_req,
    input logic [CW-1:0]    ctrl_q
);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_idx == 3'd0);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[22:6] == '0);

    assert_req_needs_arm_R4: assert property (@(posedge clk) disable iff (rst)
        dbg_req |-> (ctrl_q[B_MSTR] && ctrl_q[B_TRAP]));

    assert_read_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write && !ctrl_q[B_DRD] && !fetch_valid) |-> !dbg_req);

    assert_write_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && !ctrl_q[B_DWR] && !fetch_valid) |-> !dbg_req);

    assert_req_sets_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !ctrl_wr) |=> ctrl_q[S_TKN]);

    assert_taken_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[S_TKN] && !ctrl_wr) |=> ctrl_q[S_TKN]);

    assert_zero_disarms_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata == '0) |=> !dbg_req);
endmodule

bind dbg_bkpt_unit dbg_bkpt_chk i_chk (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .fetch_valid(fetch_valid),
    .mem_valid(mem_valid), .mem_write(mem_write),
    .dbg_req(dbg_req), .ctrl_q(ctrl_q)
);

// File: tb/test_dbg_bkpt_unit.sv
module test_dbg_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_idx;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        user_mode;
    logic        fetch_valid;
    logic [31:0] fetch_pc;
    logic        mem_valid;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic        dbg_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dbg_bkpt_unit i_dbg_bkpt_unit (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .user_mode(user_mode),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .dbg_req(dbg_req)
    );

    localparam logic [31:0] ARM  = 32'hE080_0000;
    localparam logic [31:0] PCE  = 32'h0100_0000;
    localparam logic [31:0] DAE  = 32'h0200_0000;
    localparam logic [31:0] DRD  = 32'h0400_0000;
    localparam logic [31:0] DWR  = 32'h0800_0000;
    localparam logic [31:0] TRC  = 32'h1000_0000;

    // mask, bp address, fetch pc, expected request
    localparam int NV = 8;
    localparam logic [96:0] VEC [NV] = '{
        {32'hFFFF_FFFF, 32'h1000_0040, 32'h1000_0040, 1'b1},
        {32'hFFFF_FFFF, 32'h1000_0040, 32'h1000_0044, 1'b0},
        {32'hFFFF_FF00, 32'h1000_0000, 32'h1000_00FC, 1'b1},
        {32'hFFFF_FF00, 32'h1000_0000, 32'h1000_0100, 1'b0},
        {32'h0000_0000, 32'h1234_5678, 32'hDEAD_BEEC, 1'b1},
        {32'h7FFF_FFFF, 32'h0000_1000, 32'h8000_1000, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_1000, 32'h8000_1000, 1'b0},
        {32'hFFFF_0000, 32'hABCD_0000, 32'hABCE_0000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_idx = idx; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #0.5;
        d = reg_rdata;
    endtask

    // one access cycle; returns the request seen during that cycle
    task automatic access(input logic fv, input logic [31:0] pc, input logic mv,
                          input logic mw, input logic [31:0] ma, output logic r);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; mem_valid = mv; mem_write = mw; mem_addr = ma;
        #0.5;
        r = dbg_req;
        @(negedge clk);
        fetch_valid = 1'b0; mem_valid = 1'b0;
        #0.5;
        // R7: pulse only during the access
        chk("R7", {31'd0, dbg_req}, 32'd0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic r;
        rst = 1'b1; reg_idx = 3'd0; reg_we = 1'b0; reg_wdata = '0;
        user_mode = 1'b0; fetch_valid = 1'b0; fetch_pc = '0;
        mem_valid = 1'b0; mem_write = 1'b0; mem_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
        rd(3'd1, d); chk("R1 pc addr", d, 32'h0);
        rd(3'd2, d); chk("R1 pc mask", d, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R1 da addr", d, 32'h0);
        rd(3'd4, d); chk("R1 da mask", d, 32'hFFFF_FFFF);
        access(1'b1, 32'h0, 1'b1, 1'b0, 32'h0, r);
        chk("R1 no req", {31'd0, r}, 32'd0);

        // R3 table of masked compares
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, ARM | PCE);
            wr(3'd2, VEC[i][96:65]);
            wr(3'd1, VEC[i][64:33]);
            access(1'b1, VEC[i][32:1], 1'b0, 1'b0, 32'h0, r);
            chk($sformatf("R3 vector %0d", i), {31'd0, r}, {31'd0, VEC[i][0]});
        end

        // R2 reserved bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R2 reserved", d, 32'hFF80_003F);

        // R8 flags and stickiness
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'h2000_0000);
        wr(3'd0, ARM | PCE);
        access(1'b1, 32'h2000_0000, 1'b0, 1'b0, 32'h0, r);
        rd(3'd0, d); chk("R8 pc flags", d, ARM | PCE | 32'h3);
        access(1'b1, 32'h2000_0004, 1'b0, 1'b0, 32'h0, r);
        rd(3'd0, d); chk("R8 sticky", d, ARM | PCE | 32'h3);
        wr(3'd0, ARM | PCE);
        rd(3'd0, d); chk("R8 cleared", d, ARM | PCE);

        // R4 trap enable off
        wr(3'd0, 32'h6180_0000);
        access(1'b1, 32'h2000_0000, 1'b0, 1'b0, 32'h0, r);
        chk("R4 trap off", {31'd0, r}, 32'd0);
        wr(3'd0, 32'hE100_0000);
        access(1'b1, 32'h2000_0000, 1'b0, 1'b0, 32'h0, r);
        chk("R4 master off", {31'd0, r}, 32'd0);

        // R5 mode gating: user enable clear
        wr(3'd0, 32'hA180_0000);
        user_mode = 1'b1;
        access(1'b1, 32'h2000_0000, 1'b0, 1'b0, 32'h0, r);
        chk("R5 user blocked", {31'd0, r}, 32'd0);
        rd(3'd0, d); chk("R5 no flags", d, 32'hA180_0000);
        user_mode = 1'b0;
        access(1'b1, 32'h2000_0000, 1'b0, 1'b0, 32'h0, r);
        chk("R5 kernel allowed", {31'd0, r}, 32'd1);

        // R6 data direction
        wr(3'd3, 32'h0000_8000);
        wr(3'd4, 32'hFFFF_FFF0);
        wr(3'd0, ARM | DAE | DRD);
        access(1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_8008, r);
        chk("R6 read hit", {31'd0, r}, 32'd1);
        rd(3'd0, d); chk("R6 read flags", d, ARM | DAE | DRD | 32'h0D);
        wr(3'd0, ARM | DAE | DRD);
        access(1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_8008, r);
        chk("R6 write ignored", {31'd0, r}, 32'd0);
        rd(3'd0, d); chk("R6 write no flags", d, ARM | DAE | DRD);
        wr(3'd0, ARM | DAE | DWR);
        access(1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_800C, r);
        chk("R6 write hit", {31'd0, r}, 32'd1);
        rd(3'd0, d); chk("R6 write flags", d, ARM | DAE | DWR | 32'h15);
        access(1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_8010, r);
        chk("R6 outside mask", {31'd0, r}, 32'd0);

        // R9 both at once
        wr(3'd0, ARM | PCE | DAE | DRD | DWR);
        access(1'b1, 32'h2000_0000, 1'b1, 1'b0, 32'h0000_8004, r);
        chk("R9 one req", {31'd0, r}, 32'd1);
        rd(3'd0, d); chk("R9 both flags", d, ARM | PCE | DAE | DRD | DWR | 32'h0F);

        // R11 trace
        wr(3'd0, ARM | TRC);
        access(1'b1, 32'h7777_0000, 1'b0, 1'b0, 32'h0, r);
        chk("R11 trace req", {31'd0, r}, 32'd1);
        rd(3'd0, d); chk("R11 trace flags", d, ARM | TRC | 32'h21);

        // R10 disarm
        wr(3'd0, 32'h0);
        access(1'b1, 32'h2000_0000, 1'b1, 1'b0, 32'h0000_8000, r);
        chk("R10 disarmed", {31'd0, r}, 32'd0);
        rd(3'd0, d); chk("R10 ctrl zero", d, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule